// File: doc/BRIEF.md
# Transmit Frame Gate

This block guards the transmit path of a simple Ethernet MAC. Software builds a complete frame in a byte-wide transmit buffer: an eight-byte lead-in (seven 0x55 bytes and a 0xD5 delimiter), the frame body, and four trailing check bytes. It then writes the total byte count to the block's count register. A nonzero write starts a transmit attempt. The block first checks the count against a minimum and a maximum. It then reads the eight lead-in bytes back from the buffer and compares them.

When every check passes, the block streams the frame body to the MAC one byte per cycle. The lead-in and the four trailing bytes are not sent. The count register then returns to zero. When a check fails, nothing is streamed and the count stays as written. A two-bit code records why the attempt failed. Every attempt ends with a single-cycle interrupt pulse, whether it passed or failed.

The buffer is an external synchronous memory. The block drives a byte address, and the data for that address returns on the next cycle.

Top module: `txg_gate`

## Requirements
- R1: A count write (`cnt_wr` high) while idle loads `cnt_wdata` into `cnt_q`. A nonzero value starts an attempt, with `busy` high from the next cycle. A zero value starts nothing and raises no interrupt.
- R2: A count below 64 is rejected with `err_code` = 1. No byte is streamed.
- R3: A count above 1530 is rejected with `err_code` = 2. No byte is streamed.
- R4: The length checks take precedence. A count that passes them is rejected with `err_code` = 3 unless buffer bytes 0 to 6 all read 0x55 and byte 7 reads 0xD5. No byte is streamed.
- R5: An accepted attempt streams count minus 12 bytes on `out_data`, with `out_valid` high. The bytes start at buffer offset 8, come in address order on consecutive cycles, and `out_last` is high on the final byte only.
- R6: After a successful send, `cnt_q` is zero in the cycle of the final byte. A rejected attempt leaves `cnt_q` at the written count.
- R7: Every attempt produces exactly one `tx_irq` pulse, one cycle wide. It comes in the cycle `busy` falls, which on success is the cycle of the final byte.
- R8: Count writes made while `busy` is high are ignored. This holds even in the cycle just before completion.
- R9: `err_code` is updated at the end of each attempt: 0 on success, or 1, 2 or 3 as given above.
- R10: After reset, `busy`, `tx_irq`, `out_valid` and `out_last` are low, and `cnt_q` and `err_code` are zero.
- R11: The buffer data for `buf_addr` is taken from `buf_rdata` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 12 | Byte count to write |
| cnt_q | output | 12 | Count register value |
| busy | output | 1 | An attempt is being checked or streamed |
| err_code | output | 2 | Result of the last attempt (0 ok, 1 short, 2 long, 3 bad lead-in) |
| tx_irq | output | 1 | One-cycle pulse at the end of each attempt |
| buf_addr | output | 11 | Transmit buffer byte address |
| buf_rdata | input | 8 | Buffer data, one cycle after the address |
| out_valid | output | 1 | A body byte is on `out_data` |
| out_data | output | 8 | Frame body byte to the MAC |
| out_last | output | 1 | Final body byte of the frame |

## Verification
Two things can meet in one cycle: the clearing of the count on completion, and a software write to the count register. The bench provokes this with a write timed so that it is sampled at the same edge as the final byte. It counts the timing from the first streamed byte and the known body length.

At that edge it expects three things together: `cnt_q` at zero, `out_last` and `tx_irq` high, and the write dropped. It also expects no second attempt to follow.

Random counts from all three length classes, some with a corrupted lead-in, are judged against a bench model of the accept or reject decision and of the expected byte stream.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEN  = 2'd1,
        ST_HDR  = 2'd2,
        ST_SEND = 2'd3
    } txg_state_e;

    typedef enum logic [1:0] {
        VERDICT_OK    = 2'd0,
        VERDICT_SHORT = 2'd1,
        VERDICT_LONG  = 2'd2,
        VERDICT_HDR   = 2'd3
    } txg_verdict_e;

endpackage

// File: rtl/txg_len_check.sv
module txg_len_check
    import txg_pkg::*;
#(
    parameter int CW      = 12,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1530
) (
    input  logic [CW-1:0] len,
    output txg_verdict_e  verdict
);
    localparam logic [CW-1:0] LO = CW'(MIN_LEN);
    localparam logic [CW-1:0] HI = CW'(MAX_LEN);

    always_comb begin
        if (len < LO)      verdict = VERDICT_SHORT;
        else if (len > HI) verdict = VERDICT_LONG;
        else               verdict = VERDICT_OK;
    end
endmodule

// File: rtl/txg_hdr_ref.sv
module txg_hdr_ref #(
    parameter int         AW       = 11,
    parameter int         HDR_LEN  = 8,
    parameter logic [7:0] FILL_VAL = 8'h55,
    parameter logic [7:0] SFD_VAL  = 8'hD5
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    expect_byte
);
    localparam logic [AW-1:0] SFD_IDX = AW'(HDR_LEN - 1);

    always_comb begin
        expect_byte = (idx == SFD_IDX) ? SFD_VAL : FILL_VAL;
    end
endmodule

// File: rtl/txg_gate.sv
module txg_gate
    import txg_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int MIN_LEN   = 64,
    parameter int MAX_LEN   = 1530,
    parameter int HDR_LEN   = 8,
    parameter int TRL_LEN   = 4,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    output logic [CW-1:0] cnt_q,
    output logic          busy,
    output logic [1:0]    err_code,
    output logic          tx_irq,
    output logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_rdata,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_last
);
    localparam logic [AW-1:0] HDR_END   = AW'(HDR_LEN - 1);
    localparam logic [AW-1:0] BODY_BASE = AW'(HDR_LEN);
    localparam logic [CW-1:0] TAIL_OFF  = CW'(TRL_LEN + 1);

    typedef struct packed {
        txg_state_e   state;
        logic [CW-1:0] cnt;
        txg_verdict_e err;
        logic [AW-1:0] addr;
        logic          iss;
        logic [AW-1:0] pend_a;
        logic          pend_v;
        logic          bad;
        logic          irq;
        logic          out_v;
        logic [7:0]    out_d;
        logic          out_l;
    } txg_regs_t;

    txg_regs_t    r_q, r_d;
    txg_verdict_e len_verdict;
    logic [7:0]   hdr_expect;
    logic [CW-1:0] last_idx;
    logic          hdr_mism;

    txg_len_check #(.CW(CW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
        .len     (r_q.cnt),
        .verdict (len_verdict)
    );

    txg_hdr_ref #(.AW(AW), .HDR_LEN(HDR_LEN)) u_hdr (
        .idx         (r_q.pend_a),
        .expect_byte (hdr_expect)
    );

    assign last_idx = r_q.cnt - TAIL_OFF;
    assign hdr_mism = (buf_rdata != hdr_expect);

    always_comb begin
        r_d        = r_q;
        r_d.irq    = 1'b0;
        r_d.out_v  = 1'b0;
        r_d.out_l  = 1'b0;
        r_d.pend_v = r_q.iss;
        r_d.pend_a = r_q.addr;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cnt_wr) begin
                    r_d.cnt = cnt_wdata;
                    if (cnt_wdata != '0) r_d.state = ST_LEN;
                end
            end
            ST_LEN: begin
                if (len_verdict != VERDICT_OK) begin
                    r_d.state = ST_IDLE;
                    r_d.irq   = 1'b1;
                    r_d.err   = len_verdict;
                end else begin
                    r_d.state = ST_HDR;
                    r_d.addr  = '0;
                    r_d.iss   = 1'b1;
                    r_d.bad   = 1'b0;
                end
            end
            ST_HDR: begin
                if (r_q.iss) begin
                    if (r_q.addr == HDR_END) r_d.iss  = 1'b0;
                    else                     r_d.addr = r_q.addr + AW'(1);
                end
                if (r_q.pend_v) begin
                    r_d.bad = r_q.bad | hdr_mism;
                    if (r_q.pend_a == HDR_END) begin
                        if (r_q.bad | hdr_mism) begin
                            r_d.state = ST_IDLE;
                            r_d.irq   = 1'b1;
                            r_d.err   = VERDICT_HDR;
                        end else begin
                            r_d.state = ST_SEND;
                            r_d.addr  = BODY_BASE;
                            r_d.iss   = 1'b1;
                        end
                    end
                end
            end
            ST_SEND: begin
                if (r_q.iss) begin
                    if ({1'b0, r_q.addr} == last_idx) r_d.iss  = 1'b0;
                    else                             r_d.addr = r_q.addr + AW'(1);
                end
                if (r_q.pend_v) begin
                    r_d.out_v = 1'b1;
                    r_d.out_d = buf_rdata;
                    if ({1'b0, r_q.pend_a} == last_idx) begin
                        r_d.out_l = 1'b1;
                        r_d.state = ST_IDLE;
                        r_d.irq   = 1'b1;
                        r_d.cnt   = '0;
                        r_d.err   = VERDICT_OK;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, err: VERDICT_OK, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_q     = r_q.cnt;
    assign busy      = (r_q.state != ST_IDLE);
    assign err_code  = r_q.err;
    assign tx_irq    = r_q.irq;
    assign buf_addr  = r_q.addr;
    assign out_valid = r_q.out_v;
    assign out_data  = r_q.out_d;
    assign out_last  = r_q.out_l;
endmodule

// File: rtl/txg_gate_chk.sv
module txg_gate_chk #(
    parameter int CW      = 12,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1530
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_wr,
    input logic [CW-1:0] cnt_q,
    input logic          busy,
    input logic [1:0]    err_code,
    input logic          tx_irq,
    input logic          out_valid,
    input logic          out_last
);
    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    a_r7_irq_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> !busy);

    a_r6_clear_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (cnt_q == '0 && tx_irq && err_code == 2'd0));

    a_r2_short_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && err_code == 2'd1) |-> (cnt_q < CW'(MIN_LEN) && !out_valid));

    a_r3_long_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && err_code == 2'd2) |-> (cnt_q > CW'(MAX_LEN) && !out_valid));

    a_r4_hdr_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && err_code == 2'd3) |-> !out_valid);

    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_wr) |=> (cnt_q == $past(cnt_q) || (out_last && cnt_q == '0)));

    a_r5_stream_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy || out_last));
endmodule

bind txg_gate txg_gate_chk #(.CW(CW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (cnt_wr),
    .cnt_q     (cnt_q),
    .busy      (busy),
    .err_code  (err_code),
    .tx_irq    (tx_irq),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/sim_txg_gate.sv
module sim_txg_gate;
    localparam int BUF = 2048;
    localparam int AW  = 11;
    localparam int CW  = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cnt_wr;
    logic [CW-1:0] cnt_wdata;
    logic [CW-1:0] cnt_q;
    logic          busy;
    logic [1:0]    err_code;
    logic          tx_irq;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_rdata;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_last;

    always #4 clk = ~clk;

    txg_gate u0 (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_q(cnt_q), .busy(busy), .err_code(err_code), .tx_irq(tx_irq),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    logic [7:0] mem [BUF];
    logic [7:0] cap [BUF];
    int cap_n, irq_n, last_n, last_pos;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // R11: synchronous buffer, one cycle of read latency
    always @(posedge clk) buf_rdata <= mem[buf_addr];

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && cap_n < BUF) begin
                cap[cap_n] = out_data;
                if (out_last) begin
                    last_n++;
                    last_pos = cap_n;
                end
                cap_n++;
            end
            if (tx_irq) irq_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int count, input bit hdr_ok);
        if (count < 64)   return 1;
        if (count > 1530) return 2;
        if (!hdr_ok)      return 3;
        return 0;
    endfunction

    task automatic fill(input int count, input int bad_idx);
        for (int i = 0; i < 8; i++) mem[i] = (i == 7) ? 8'hD5 : 8'h55;
        for (int i = 8; i < count && i < BUF; i++) mem[i] = 8'($urandom);
        if (bad_idx >= 0) mem[bad_idx] = mem[bad_idx] ^ 8'h10;
    endtask

    task automatic clear_mon();
        cap_n = 0; irq_n = 0; last_n = 0; last_pos = -1;
    endtask

    task automatic attempt(input int count, input int bad_idx);
        int e, t, mism;
        string req;
        fill(count, bad_idx);
        clear_mon();
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = CW'(count);
        @(negedge clk); cnt_wr = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        t = 0;
        while (irq_n == 0 && t < 4000) begin @(posedge clk); t++; end
        repeat (2) @(negedge clk);
        e = exp_code(count, bad_idx < 0);
        req = (e == 1) ? "R2" : (e == 2) ? "R3" : (e == 3) ? "R4" : "R5";
        chk("R7 one irq per attempt", irq_n, 1);
        chk("R9 err code", int'(err_code), e);
        if (e == 0) begin
            chk("R5 byte count", cap_n, count - 12);
            mism = 0;
            for (int i = 0; i < count - 12; i++) if (cap[i] != mem[i + 8]) mism++;
            chk("R5 R11 body bytes", mism, 0);
            chk("R5 last flag position", last_pos, count - 13);
            chk("R5 single last flag", last_n, 1);
            chk("R6 count cleared", int'(cnt_q), 0);
        end else begin
            chk({req, " nothing streamed"}, cap_n, 0);
            chk("R6 count kept on reject", int'(cnt_q), count);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n, sel, cnt, bad;
        void'($urandom(32'd1234));
        rst_n = 1'b0; cnt_wr = 1'b0; cnt_wdata = '0;
        clear_mon();
        for (int i = 0; i < BUF; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy", int'(busy), 0);
        chk("R10 irq", int'(tx_irq), 0);
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 out_last", int'(out_last), 0);
        chk("R10 count", int'(cnt_q), 0);
        chk("R10 err", int'(err_code), 0);

        // R1: zero write starts nothing
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = '0;
        @(negedge clk); cnt_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 zero write not busy", int'(busy), 0);
        chk("R1 zero write no irq", irq_n, 0);
        chk("R1 zero write count", int'(cnt_q), 0);

        attempt(63, -1);
        attempt(64, -1);
        attempt(1530, -1);
        attempt(1531, -1);
        attempt(2047, -1);
        attempt(100, 7);
        attempt(100, 0);
        attempt(40, 3);
        attempt(70, -1);

        // R8: write during streaming is ignored
        fill(200, -1);
        clear_mon();
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = CW'(200);
        @(negedge clk); cnt_wr = 1'b0;
        repeat (40) @(negedge clk);
        cnt_wr = 1'b1; cnt_wdata = CW'(70);
        @(negedge clk); cnt_wr = 1'b0;
        repeat (300) @(negedge clk);
        chk("R8 busy write ignored bytes", cap_n, 188);
        chk("R8 busy write ignored irq", irq_n, 1);
        chk("R8 busy write count", int'(cnt_q), 0);
        chk("R8 idle afterwards", int'(busy), 0);

        // R8 R6 R7: write sampled at the same edge as the final byte
        n = 52;
        fill(64, -1);
        clear_mon();
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = CW'(64);
        @(negedge clk); cnt_wr = 1'b0;
        while (!out_valid) @(negedge clk);
        repeat (n - 2) @(posedge clk);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = CW'(99);
        @(posedge clk);
        @(negedge clk); cnt_wr = 1'b0;
        chk("R5 last byte at coincident edge", int'(out_last), 1);
        chk("R7 irq at coincident edge", int'(tx_irq), 1);
        chk("R6 clear wins over write", int'(cnt_q), 0);
        repeat (30) @(negedge clk);
        chk("R8 coincident write not started", irq_n, 1);
        chk("R8 coincident write idle", int'(busy), 0);

        for (int k = 0; k < 14; k++) begin
            sel = int'($urandom % 4);
            bad = -1;
            case (sel)
                0: cnt = 20 + int'($urandom % 44);
                1: cnt = 1531 + int'($urandom % 500);
                2: cnt = 64 + int'($urandom % 300);
                default: begin
                    cnt = 64 + int'($urandom % 300);
                    bad = int'($urandom % 8);
                end
            endcase
            attempt(cnt, bad);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule